// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the interrupt state of a parallel peripheral interface. Seven event sources feed it: two control inputs on each of two ports, a shift unit and two timers. Each source sends a one-cycle set pulse, and the block stores it in a flag register until something clears it. A second register holds the enable mask for the same seven sources. The interrupt line is raised whenever a flag and its enable bit are both 1.

The host reaches both registers through a small register bus. Offset 13 holds the flags and offset 14 holds the enables. The block also watches accesses to other offsets of the same bus, because some reads and writes acknowledge a source. Reading a port acknowledges that port's control-line events. Any access to the shift unit acknowledges the shift event. Sources whose acknowledge is decoded outside the block, such as the timers, use a separate per-source clear input.

Top module: `irq_ctl_top`

## Requirements
- R1: After a synchronous reset, every flag and enable bit is 0, `irq` is 0 and `rd_data` is 0.
- R2: A pulse on `src_set[i]` sets flag bit i, and the flag stays set until it is cleared. The bit positions are: 0 = port A control 2, 1 = port A control 1, 2 = shift unit, 3 = port B control 2, 4 = port B control 1, 5 = timer 2, 6 = timer 1.
- R3: A write to offset 13 clears each flag whose bit in `bus_wdata[6:0]` is 1. All other flags keep their value.
- R4: A write to offset 14 with `bus_wdata[7]`=1 ORs `bus_wdata[6:0]` into the enable register.
- R5: A write to offset 14 with `bus_wdata[7]`=0 clears each enable bit whose bit in `bus_wdata[6:0]` is 1.
- R6: `irq` is a register. It equals the OR over all i of (flag[i] AND enable[i]), evaluated after the clock edge that updates flags and enables.
- R7: A read of offset 13 returns {`irq`, flags[6:0]} on `rd_data` in the next cycle. The value shows the state from before any clear caused by that same access.
- R8: A read of offset 14 returns {1, enables[6:0]} in the next cycle. A read of any other offset, and any cycle with no read, gives `rd_data` = 0.
- R9: A read of offset 0 clears flags 3 and 4. A read of offset 1 or offset 15 clears flags 0 and 1. Writes to these offsets clear nothing.
- R10: A read or a write at offset 10 clears flag 2.
- R11: `src_clr[i]` = 1 clears flag i.
- R12: When a set pulse and any clear for the same flag occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| src_set | input | 7 | Per-source set pulses |
| src_clr | input | 7 | Per-source clear pulses from external decode |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that set and clear inputs are sampled only on the clock edge. They also assume that a single access lasts exactly one strobe cycle, because the clear caused by an access is tied to that cycle. The stimulus drives every input on the falling edge. It uses one-cycle strobes with random offsets, directions, data and pulses, and it frequently places set and clear requests in the same cycle so that the set-wins case is exercised.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N = 7;
  localparam int DW    = SRC_N + 1;
  localparam int B_CA2 = 0;
  localparam int B_CA1 = 1;
  localparam int B_SHF = 2;
  localparam int B_CB2 = 3;
  localparam int B_CB1 = 4;
  localparam int B_TM2 = 5;
  localparam int B_TM1 = 6;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_pkg::*;
#(
  parameter int AW = 4,
  parameter logic [AW-1:0] A_PORTB  = 4'd0,
  parameter logic [AW-1:0] A_PORTA  = 4'd1,
  parameter logic [AW-1:0] A_PORTA2 = 4'd15,
  parameter logic [AW-1:0] A_SHIFT  = 4'd10,
  parameter logic [AW-1:0] A_FLAG   = 4'd13,
  parameter logic [AW-1:0] A_ENAB   = 4'd14
) (
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output src_vec_t      acc_clr,
  output logic          en_wr,
  output logic          rd_flag,
  output logic          rd_enab
);
  logic rd, wr_s;
  assign rd   = sel && !wr;
  assign wr_s = sel && wr;

  always_comb begin
    acc_clr = '0;
    if (wr_s && addr == A_FLAG) acc_clr = wdata[SRC_N-1:0];
    if (rd && addr == A_PORTB) begin
      acc_clr[B_CB1] = 1'b1;
      acc_clr[B_CB2] = 1'b1;
    end
    if (rd && (addr == A_PORTA || addr == A_PORTA2)) begin
      acc_clr[B_CA1] = 1'b1;
      acc_clr[B_CA2] = 1'b1;
    end
    if (sel && addr == A_SHIFT) acc_clr[B_SHF] = 1'b1;
  end

  assign en_wr   = wr_s && addr == A_ENAB;
  assign rd_flag = rd && addr == A_FLAG;
  assign rd_enab = rd && addr == A_ENAB;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t set,
  input  src_vec_t clr,
  output src_vec_t flag_nx,
  output src_vec_t flag_q
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    assign flag_nx[i] = set[i] | (flag_q[i] & ~clr[i]);
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_nx[i];
    end
  end

  // R12 / R2: a set pulse always leaves its flag set
  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((flag_q & $past(set)) == $past(set)));
  // R3 / R11: a cleared flag with no set goes low
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> ((flag_q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output src_vec_t      en_nx,
  output src_vec_t      en_q
);
  always_comb begin
    en_nx = en_q;
    if (wr) begin
      if (wdata[DW-1]) en_nx = en_q | wdata[SRC_N-1:0];
      else             en_nx = en_q & ~wdata[SRC_N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nx;
  end

  p_en_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[DW-1]) |=> ((en_q & $past(wdata[SRC_N-1:0])) == $past(wdata[SRC_N-1:0])));
  p_en_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[DW-1]) |=> ((en_q & $past(wdata[SRC_N-1:0])) == '0));
  p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(en_q));
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [SRC_N-1:0] src_set,
  input  logic [SRC_N-1:0] src_clr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  src_vec_t acc_clr, flag_nx, flag_q, en_nx, en_q;
  logic     en_wr, rd_flag, rd_enab;

  irq_decode #(.AW(AW)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .acc_clr(acc_clr), .en_wr(en_wr), .rd_flag(rd_flag), .rd_enab(rd_enab)
  );

  irq_flag_reg u_flag (
    .clk(clk), .rst(rst), .set(src_set), .clr(acc_clr | src_clr),
    .flag_nx(flag_nx), .flag_q(flag_q)
  );

  irq_enable_reg u_en (
    .clk(clk), .rst(rst), .wr(en_wr), .wdata(bus_wdata),
    .en_nx(en_nx), .en_q(en_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      irq <= |(flag_nx & en_nx);
      if (rd_flag)      rd_data <= {irq, flag_q};
      else if (rd_enab) rd_data <= {1'b1, en_q};
      else              rd_data <= '0;
    end
  end

  p_irq_match_r6: assert property (@(posedge clk) disable iff (rst)
    irq == |(flag_q & en_q));
  p_en_read_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == 4'd14) |=> rd_data[DW-1]);
  p_flag_read_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == 4'd13) |=> (rd_data[DW-1] == $past(irq)));
endmodule

// File: tb/test_irq_ctl_top.sv
module test_irq_ctl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [6:0] src_set = '0, src_clr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R1", m_tag = "R1";

  int m_flag = 0, m_en = 0, m_irq = 0, m_rd = 0;

  always #5 clk = ~clk;

  irq_ctl_top i_irq_ctl_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_set(src_set),
    .src_clr(src_clr), .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference, evaluated from the inputs seen at each rising edge
  always @(posedge clk) begin
    int clr, a, rd;
    m_tag = cur_tag;
    if (rst) begin
      m_flag = 0; m_en = 0; m_irq = 0; m_rd = 0;
    end else begin
      a = bus_addr;
      rd = bus_sel && !bus_wr;
      if (rd && a == 13)      m_rd = m_irq * 128 + m_flag;
      else if (rd && a == 14) m_rd = 128 + m_en;
      else                    m_rd = 0;
      clr = src_clr;
      if (bus_sel && bus_wr && a == 13) clr = clr | (bus_wdata & 8'h7f);
      if (rd && a == 0)               clr = clr | 'h18;
      if (rd && (a == 1 || a == 15))  clr = clr | 'h03;
      if (bus_sel && a == 10)         clr = clr | 'h04;
      m_flag = (m_flag & ~clr & 'h7f) | src_set;
      if (bus_sel && bus_wr && a == 14) begin
        if (bus_wdata[7]) m_en = m_en | (bus_wdata & 8'h7f);
        else              m_en = m_en & ~(bus_wdata & 8'h7f) & 'h7f;
      end
      m_irq = ((m_flag & m_en) != 0) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (irq !== m_irq[0]) begin
        fails++;
        $display("FAIL %s/R6 irq actual=%0d expected=%0d", m_tag, irq, m_irq);
      end
      checks++;
      if (rd_data !== m_rd[7:0]) begin
        fails++;
        $display("FAIL %s rd_data actual=%02h expected=%02h", m_tag, rd_data, m_rd[7:0]);
      end
    end
  end

  task automatic cyc(input bit s, input bit w, input int a, input int d,
                     input int st, input int cl, input string tag);
    @(negedge clk);
    cur_tag = tag;
    bus_sel = s; bus_wr = w; bus_addr = a[3:0]; bus_wdata = d[7:0];
    src_set = st[6:0]; src_clr = cl[6:0];
  endtask

  task automatic expect_read(input int a, input int exp, input string tag);
    cyc(1, 0, a, 0, 0, 0, tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
    checks++;
    if (rd_data !== exp[7:0]) begin
      fails++;
      $display("FAIL %s directed read actual=%02h expected=%02h", tag, rd_data, exp[7:0]);
    end
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    expect_read(13, 'h00, "R1");
    expect_read(14, 'h80, "R1");
    // R2: set all sources, flags hold, no irq with no enables
    cyc(0, 0, 0, 0, 'h7f, 0, "R2");
    expect_read(13, 'h7f, "R2");
    // R4: enable timer 1 -> irq
    cyc(1, 1, 14, 'hc0, 0, 0, "R4");
    expect_read(14, 'hc0, "R4");
    expect_read(13, 'hff, "R7");
    // R5: disable timer 1
    cyc(1, 1, 14, 'h40, 0, 0, "R5");
    expect_read(14, 'h80, "R5");
    // R3: clear flags 5 and 6
    cyc(1, 1, 13, 'h60, 0, 0, "R3");
    expect_read(13, 'h1f, "R3");
    // R9: writes to port offsets do not clear
    cyc(1, 1, 0, 'hff, 0, 0, "R9");
    cyc(1, 1, 1, 'hff, 0, 0, "R9");
    expect_read(13, 'h1f, "R9");
    expect_read(0, 'h00, "R9");
    expect_read(13, 'h07, "R9");
    expect_read(15, 'h00, "R9");
    expect_read(13, 'h04, "R9");
    // R10: write at shift offset clears flag 2
    cyc(1, 1, 10, 'h00, 0, 0, "R10");
    expect_read(13, 'h00, "R10");
    // R11 and R12
    cyc(0, 0, 0, 0, 'h21, 0, "R11");
    cyc(0, 0, 0, 0, 0, 'h01, "R11");
    expect_read(13, 'h20, "R11");
    cyc(1, 1, 13, 'h7f, 'h08, 'h08, "R12");
    expect_read(13, 'h08, "R12");
    // random traffic compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      int ad;
      ad = ($urandom % 4 == 0) ? 13 + ($urandom % 2) : int'($urandom % 16);
      cyc(($urandom % 3) != 0, $urandom % 2, ad, $urandom % 256,
          (($urandom % 4) == 0) ? int'($urandom % 128) : 0,
          (($urandom % 5) == 0) ? int'($urandom % 128) : 0, "R12");
    end
    cyc(0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule